// File: doc/BRIEF.md
# Peripheral Request Channel Mapper

This block sits between a set of peripheral DMA request lines and a bank of DMA channels. A programmable mapping register for each request line holds a valid flag and a target channel number. Each asserted request whose mapping is valid is steered onto the channel it names. Several request lines may share one channel.

Each cycle, a fixed-priority selector looks at the channels that are both running and receiving a routed request, and picks one of them to service next. Channels fall into four priority tiers, taken from bits 3:2 of the channel index, so the tier pattern repeats every 16 channels. Within a tier, the lowest index wins. The result leaves the block as a registered one-hot grant.

Software programs the mapping registers through a simple register port. Writes are synchronous. Reads are combinational from the address. Request numbers below 64 and request numbers from 64 up each have their own address window.

Top module: `reqChannelMapper`

## Requirements
- R1: The mapping register for request r < 64 is at byte address 0x100 + 4*r. A write lands at the next clock edge and reads back through the read port.
- R2: The mapping register for request r >= 64 is at byte address 0x1100 + 4*(r-64). It is reachable only for r < NUM_REQ.
- R3: In a mapping register, bit 7 is the valid flag and bits 4:0 are the target channel number. All other read bits are zero, and the write values of those bits are discarded.
- R4: After reset, every mapping register reads zero (invalid, channel 0) and the grant output is all zero.
- R5: A request line is routed to its channel only while its valid flag is set. An invalid mapping produces no grant.
- R6: When several request lines map to the same channel, their routed requests are ORed, so any one of them makes that channel request.
- R7: A channel can be granted only while its chanActive bit is high. A routed request on an inactive channel yields no grant.
- R8: The priority tier of channel c is bits 3:2 of c, where tier 0 is the highest. Channels 0-3 and 16-19 share tier 0, and channels 12-15 and 28-31 share tier 3. A requesting channel in a better tier always wins.
- R9: Among eligible channels of one tier, the lowest-numbered channel wins.
- R10: chanGrant is one-hot, or all zero when no channel is eligible. It reflects the inputs sampled at the previous clock edge, which is one cycle of latency.
- R11: Writes to addresses outside both windows, to non-word-aligned addresses, or to window slots at or beyond NUM_REQ change no register. Reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (14) | Register byte address |
| regWrData | input | DATA_W (32) | Register write data |
| regRdData | output | DATA_W (32) | Register read data, combinational from regAddr |
| periphReq | input | NUM_REQ (96) | Peripheral request lines |
| chanActive | input | NUM_CH (32) | Per-channel running mask |
| chanGrant | output | NUM_CH (32) | Registered one-hot grant |

## Verification
Three latencies apply. A read is due in the same cycle its address is driven. A write becomes visible after the one clock edge that captures it. A grant appears after exactly one edge following a change to periphReq or chanActive.

The bench drives every input on the falling edge. It samples read data shortly after driving the address. It samples grants on the next falling edge, once the single capturing edge has passed. One check looks just before that edge and confirms the grant still holds its old value. Expected grants come from an arithmetic model of the tier-then-index rule, applied over directed corner cases and a sparse pseudo-random sweep over all 96 request lines.

// File: rtl/reqmap_pkg.sv
package reqmap_pkg;
  localparam int IDX_W     = 7;        // up to 128 request lines
  localparam int WIN0_BASE = 'h0100;   // requests 0..63
  localparam int WIN1_BASE = 'h1100;   // requests 64..127
  localparam int WIN_SLOTS = 64;

  typedef struct packed {
    logic             hit;   // address selects an implemented register
    logic             wrEn;  // qualified write strobe
    logic [IDX_W-1:0] idx;   // request number addressed
  } mapStrobe_t;
endpackage

// File: rtl/mapAddrDecode.sv
module mapAddrDecode
  import reqmap_pkg::*;
#(
  parameter int NUM_REQ = 96,
  parameter int ADDR_W  = 14
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output mapStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] BASE0 = ADDR_W'(WIN0_BASE);
  localparam logic [ADDR_W-1:0] BASE1 = ADDR_W'(WIN1_BASE);
  localparam logic [ADDR_W-1:0] SPAN  = ADDR_W'(WIN_SLOTS * 4);

  logic [ADDR_W-1:0] off0, off1;
  logic              in0, in1;
  logic [IDX_W-1:0]  idx0, idx1;

  always_comb begin
    off0 = regAddr - BASE0;
    off1 = regAddr - BASE1;
    in0  = (regAddr >= BASE0) && (off0 < SPAN) && (off0[1:0] == 2'b00);
    in1  = (regAddr >= BASE1) && (off1 < SPAN) && (off1[1:0] == 2'b00);
    idx0 = {1'b0, off0[7:2]};
    idx1 = {1'b1, off1[7:2]};
    strb.hit = 1'b0;
    strb.idx = '0;
    if (in0 && (int'(idx0) < NUM_REQ)) begin
      strb.hit = 1'b1;
      strb.idx = idx0;
    end else if (in1 && (int'(idx1) < NUM_REQ)) begin
      strb.hit = 1'b1;
      strb.idx = idx1;
    end
    strb.wrEn = strb.hit && regWrEn;
  end
endmodule

// File: rtl/mapRegFile.sv
module mapRegFile
  import reqmap_pkg::*;
#(
  parameter int NUM_REQ = 96,
  parameter int NUM_CH  = 32,
  parameter int DATA_W  = 32,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapStrobe_t         strb,
  input  logic               wrValid,
  input  logic [CH_W-1:0]    wrChan,
  input  logic [NUM_REQ-1:0] periphReq,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_CH-1:0]  routedReq
);
  localparam logic [DATA_W-1:0] LIVE_BITS = DATA_W'(32'h80) | DATA_W'((1 << CH_W) - 1);

  logic [NUM_REQ-1:0] mapValid;
  logic [CH_W-1:0]    mapChan [NUM_REQ];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_REQ; r++) begin
      if (!rstN) begin
        mapValid[r] <= 1'b0;
        mapChan[r]  <= '0;
      end else if (strb.wrEn && (strb.idx == IDX_W'(r))) begin
        mapValid[r] <= wrValid;
        mapChan[r]  <= wrChan;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.hit) begin
      rdData[7]      = mapValid[strb.idx];
      rdData[CH_W-1:0] = mapChan[strb.idx];
    end
  end

  // One OR-reduction per channel over all request lines that target it.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_route
    logic anyHit;
    always_comb begin
      anyHit = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        anyHit = anyHit | (periphReq[r] & mapValid[r] & (mapChan[r] == CH_W'(c)));
      end
    end
    assign routedReq[c] = anyHit;
  end

  a_r4_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (mapValid == '0));

  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (mapValid[$past(strb.idx)] == $past(wrValid)) &&
                  (mapChan[$past(strb.idx)] == $past(wrChan)));

  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~LIVE_BITS) == '0);
endmodule

// File: rtl/chanArbiter.sv
module chanArbiter #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] routedReq,
  input  logic [NUM_CH-1:0] chanActive,
  output logic [NUM_CH-1:0] chanGrant
);
  localparam int NUM_TIERS = 4;

  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] pick;
  logic              found;

  assign eligible = routedReq & chanActive;

  // Scan tiers best-first; inside a tier take the lowest index.
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int t = 0; t < NUM_TIERS; t++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (!found && (((c >> 2) & 3) == t) && eligible[c]) begin
          pick[c] = 1'b1;
          found   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) chanGrant <= '0;
    else       chanGrant <= pick;
  end

  a_r10_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanGrant));

  a_r7_idle_no_grant: assert property (@(posedge clk) disable iff (!rstN)
    ((routedReq & chanActive) == '0) |=> (chanGrant == '0));

  a_r10_grant_follows: assert property (@(posedge clk) disable iff (!rstN)
    ((routedReq & chanActive) != '0) |=> (chanGrant != '0));
endmodule

// File: rtl/reqChannelMapper.sv
module reqChannelMapper
  import reqmap_pkg::*;
#(
  parameter int NUM_REQ = 96,
  parameter int NUM_CH  = 32,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_REQ-1:0] periphReq,
  input  logic [NUM_CH-1:0]  chanActive,
  output logic [NUM_CH-1:0]  chanGrant
);
  localparam int CH_W = $clog2(NUM_CH);

  mapStrobe_t        strb;
  logic [NUM_CH-1:0] routedReq;
  logic              unusedWrBits;

  assign unusedWrBits = ^{regWrData[DATA_W-1:8], regWrData[6:CH_W]};

  mapAddrDecode #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) uDecode (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  mapRegFile #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .DATA_W(DATA_W)) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrValid   (regWrData[7]),
    .wrChan    (regWrData[CH_W-1:0]),
    .periphReq (periphReq),
    .rdData    (regRdData),
    .routedReq (routedReq)
  );

  chanArbiter #(.NUM_CH(NUM_CH)) uArb (
    .clk        (clk),
    .rstN       (rstN),
    .routedReq  (routedReq),
    .chanActive (chanActive),
    .chanGrant  (chanGrant)
  );
endmodule

// File: tb/sim_reqChannelMapper.sv
module sim_reqChannelMapper;
  localparam int NREQ = 96;
  localparam int NCH  = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWrEn = 1'b0;
  logic [13:0]     regAddr = '0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic [NREQ-1:0] periphReq = '0;
  logic [NCH-1:0]  chanActive = '0;
  logic [NCH-1:0]  chanGrant;

  int  nTests = 0;
  int  nFail  = 0;
  bit  finished = 1'b0;
  bit  mapV [NREQ];
  int  mapC [NREQ];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  reqChannelMapper u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .periphReq(periphReq),
    .chanActive(chanActive), .chanGrant(chanGrant)
  );

  function automatic int addrOf(int r);
    return (r < 64) ? ('h100 + 4 * r) : ('h1100 + 4 * (r - 64));
  endfunction

  function automatic logic [31:0] nextRnd(logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [NCH-1:0] expGrant(logic [NREQ-1:0] req, logic [NCH-1:0] act);
    logic [NCH-1:0] elig = '0;
    for (int r = 0; r < NREQ; r++)
      if (req[r] && mapV[r]) elig[mapC[r]] = 1'b1;
    elig = elig & act;
    for (int t = 0; t < 4; t++)
      for (int c = 0; c < NCH; c++)
        if (((c / 4) % 4) == t && elig[c]) return NCH'(1) << c;
    return '0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(int a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a[13:0]; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regReadCheck(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    regAddr = a[13:0];
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic setMap(int r, bit v, int c);
    regWrite(addrOf(r), {24'd0, v, 2'b00, c[4:0]});
    mapV[r] = v; mapC[r] = c;
  endtask

  task automatic driveAndCheck(logic [NREQ-1:0] req, logic [NCH-1:0] act, string tag);
    @(negedge clk);
    periphReq = req; chanActive = act;
    @(negedge clk);
    check(tag, chanGrant, expGrant(req, act));
  endtask

  function automatic logic [NREQ-1:0] bits2(int a, int b);
    logic [NREQ-1:0] v = '0;
    v[a] = 1'b1; v[b] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREQ; r++) begin mapV[r] = 0; mapC[r] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R4: reset state
    regReadCheck('h100, 32'h0, "R4 reg0 after reset");
    regReadCheck('h117C, 32'h0, "R4 reg95 after reset");
    check("R4 grant after reset", 32'(chanGrant), 32'h0);

    // R1 / R2: write every register, read each back
    for (int r = 0; r < NREQ; r++) setMap(r, 1'b1, (r * 7 + 3) % 32);
    for (int r = 0; r < NREQ; r++)
      regReadCheck(addrOf(r), {24'd0, 1'b1, 2'b00, 5'((r * 7 + 3) % 32)},
                   (r < 64) ? "R1 window0 readback" : "R2 window1 readback");

    // R3: field layout, other bits dropped
    regWrite('h104, 32'hFFFF_FF5F);
    regReadCheck('h104, 32'h0000_001F, "R3 valid clear, chan 31");
    regWrite('h104, 32'hFFFF_FFFF);
    regReadCheck('h104, 32'h0000_009F, "R3 all ones");

    // R11: unimplemented or unaligned addresses
    regWrite('h1180, 32'h0000_0085);
    regReadCheck('h1180, 32'h0, "R11 slot past NUM_REQ");
    regWrite('h0FC, 32'h0000_0085);
    regReadCheck('h0FC, 32'h0, "R11 below window");
    regWrite('h101, 32'h0000_0081);
    regReadCheck('h100, 32'h0000_0083, "R11 unaligned write ignored");
    regReadCheck('h101, 32'h0, "R11 unaligned read zero");

    // clear all maps
    for (int r = 0; r < NREQ; r++) setMap(r, 1'b0, 0);

    // R5: valid gating
    setMap(5, 1'b0, 7);
    driveAndCheck(bits2(5, 5), '1, "R5 invalid map no grant");
    setMap(5, 1'b1, 7);
    driveAndCheck(bits2(5, 5), '1, "R5 valid map grants ch7");

    // R6: shared channel
    setMap(10, 1'b1, 9);
    setMap(70, 1'b1, 9);
    driveAndCheck(bits2(70, 70), '1, "R6 line70 to ch9");
    driveAndCheck(bits2(10, 10), '1, "R6 line10 to ch9");

    // R7: inactive channel
    driveAndCheck(bits2(70, 70), ~(32'h1 << 9), "R7 inactive ch9");

    // R8 / R9: tiers
    setMap(20, 1'b1, 20);
    setMap(21, 1'b1, 16);
    setMap(80, 1'b1, 4);
    setMap(30, 1'b1, 15);
    setMap(31, 1'b1, 28);
    setMap(40, 1'b1, 3);
    driveAndCheck(bits2(20, 21), '1, "R8 ch16 tier0 over ch20");
    check("R8 expect ch16", 32'(chanGrant), 32'h1 << 16);
    driveAndCheck(bits2(20, 80), '1, "R9 ch4 over ch20 same tier");
    driveAndCheck(bits2(30, 31), '1, "R9 ch15 over ch28 tier3");
    driveAndCheck(bits2(30, 80), '1, "R8 tier1 over tier3");
    driveAndCheck(bits2(40, 21), '1, "R9 ch3 over ch16 tier0");
    check("R9 expect ch3", 32'(chanGrant), 32'h1 << 3);

    // R10: one cycle latency
    @(negedge clk);
    periphReq = bits2(30, 30); chanActive = '1;
    #1;
    check("R10 grant holds before edge", 32'(chanGrant), 32'h1 << 3);
    @(negedge clk);
    check("R10 grant after one edge", 32'(chanGrant), 32'h1 << 15);

    // R10 / R8 / R9: sparse pseudo-random sweep
    for (int r = 0; r < NREQ; r++) begin
      seed = nextRnd(seed);
      setMap(r, seed[0] | seed[1], int'(seed[8:4]));
    end
    for (int i = 0; i < 400; i++) begin
      logic [NREQ-1:0] rq;
      logic [NCH-1:0]  ac;
      for (int w = 0; w < 3; w++) begin
        logic [31:0] a, b, c;
        seed = nextRnd(seed); a = seed;
        seed = nextRnd(seed); b = seed;
        seed = nextRnd(seed); c = seed;
        rq[w*32 +: 32] = a & b & c;
      end
      seed = nextRnd(seed); ac = seed;
      seed = nextRnd(seed); ac = ac | seed;
      driveAndCheck(rq, ac, "R10 random sweep");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule